// File: doc/BRIEF.md
# Handshaked Shift-Register Packet Link

This block is a byte-serial packet engine that sits between a host processor and a small controller. The two sides exchange whole packets one byte at a time through an 8-bit shift register. Three active-low handshake lines on an 8-bit port carry the protocol. The host drives the in-progress and acknowledge lines, and the engine drives the request line. A direction bit in an auxiliary control byte chooses the mode. In send mode the host pushes bytes into the engine. In receive mode the engine hands queued reply bytes to the host.

In send mode, bytes are collected into a 16-entry buffer. When the host releases in-progress, the engine announces a finished packet with a one-cycle pulse and its length, and the controller reads the bytes back through a read port. In receive mode, the controller first loads up to 128 reply bytes through a write port and then commits a length. The engine announces pending data by asserting request. It presents one byte per handshake step, and it deasserts request when the last byte has been loaded. A single interrupt flag marks every step. Bytes do not move on shift clocks: they move whenever the combined acknowledge/in-progress state changes. The port is sampled on every clock edge, and all outputs are registered.

Top module: `link_shift_engine`

## Requirements
- R1: After reset the request line `treq_n_o` is high (deasserted), the flag is 0, the shift register reads 0x00 and no packet pulse is present.
- R2: Send mode is `aux_ctrl_i` bit 4 = 1. In this mode, while in-progress (`portb_i` bit 5) is low, every cycle in which bits {5,4} differ from the previous cycle appends the shift register value to the collection buffer at the next index and sets the flag.
- R3: Receive mode is `aux_ctrl_i` bit 4 = 0. In this mode, while in-progress is low, every change of bits {5,4} loads the next unread reply byte into the shift register and sets the flag. When no reply byte is left, a change leaves both the shift register and the flag unchanged.
- R4: The update that loads the last unread reply byte also drives `treq_n_o` high.
- R5: This requirement covers the idle sync case, where in-progress is high in the current cycle and in the previous one. In that case, a change of acknowledge (`portb_i` bit 4) makes `treq_n_o` copy the new bit 4 level and sets the flag.
- R6: On the cycle in which in-progress goes from low to high, the flag is set. If at least one byte was collected, `pkt_valid_o` pulses for one cycle with `pkt_len_o` equal to the count, and the collection index returns to 0.
- R7: When in-progress is high and no sync change occurs (R5), `treq_n_o` is driven low whenever unread reply bytes remain.
- R8: `rep_commit_i` sets the reply count to `rep_len_i`, clamped to 128. It also resets the read index to 0 and sets the flag. A commit takes precedence over a handshake step in the same cycle.
- R9: In send mode, bytes beyond the 16th are dropped: they are not stored, they do not set the flag, and the reported length stays 16.
- R10: `flag_clr_i` clears the flag. If the flag is set by an event in the same cycle, the set wins.
- R11: `sr_we_i` loads `sr_wdata_i` into the shift register. A reply byte loaded in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| portb_i | input | 8 | Host port: bit 5 in-progress (active low), bit 4 acknowledge (active low); other bits ignored |
| aux_ctrl_i | input | 8 | Bit 4: 1 = host sends, 0 = host receives; other bits ignored |
| sr_we_i | input | 1 | Host write strobe for the shift register |
| sr_wdata_i | input | 8 | Host data for the shift register |
| flag_clr_i | input | 1 | Clears the step flag |
| rep_we_i | input | 1 | Reply buffer write enable |
| rep_waddr_i | input | 7 | Reply buffer write address |
| rep_wdata_i | input | 8 | Reply buffer write data |
| rep_len_i | input | 8 | Reply length, sampled on commit |
| rep_commit_i | input | 1 | Commits a reply packet of `rep_len_i` bytes |
| col_raddr_i | input | 4 | Collection buffer read address |
| treq_n_o | output | 1 | Transfer request to the host, active low |
| sr_o | output | 8 | Shift register contents |
| sr_flag_o | output | 1 | Step flag (interrupt) |
| pkt_valid_o | output | 1 | One-cycle pulse when a collected packet ends |
| pkt_len_o | output | 5 | Length of the packet that ended |
| col_rdata_o | output | 8 | Collection buffer byte at `col_raddr_i` (combinational) |

## Verification
The hardest state to reach is the overflow of the collection buffer. It needs seventeen alternating acknowledge edges while in-progress stays low, so the stimulus writes a fresh shift-register value before each edge and toggles bit 4 in a loop. It then checks that the 17th edge leaves the flag clear and that the release reports a length of 16. Another hard case is a flag clear that lands in the same cycle as a receive step: the flag clear is driven in the same cycle as a toggle of bit 4. Re-committing a half-read reply while request is still asserted is also exercised, to show that reading restarts at the first byte.

// File: rtl/link_pkg.sv
package link_pkg;
    localparam int ACK_BIT = 4;
    localparam int TIP_BIT = 5;
    localparam int DIR_BIT = 4;

    typedef struct packed {
        logic tip_now;
        logic tip_prev;
        logic pair_chg;
        logic ack_chg;
        logic ack_lvl;
    } hs_evt_t;
endpackage

// File: rtl/link_hs_detect.sv
module link_hs_detect
    import link_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] lines_i,
    output hs_evt_t    evt_o
);
    // lines_i = {in_progress_n, ack_n}; idle level is high
    logic [1:0] prev_d, prev_q;

    always_comb begin
        prev_d         = lines_i;
        evt_o.tip_now  = ~lines_i[1];
        evt_o.tip_prev = ~prev_q[1];
        evt_o.pair_chg = (lines_i != prev_q);
        evt_o.ack_chg  = (lines_i[0] != prev_q[0]);
        evt_o.ack_lvl  = lines_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b11;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/link_byte_store.sv
module link_byte_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/link_shift_engine.sv
module link_shift_engine
    import link_pkg::*;
#(
    parameter int REPLY_DEPTH   = 128,
    parameter int COLLECT_DEPTH = 16,
    parameter int DW            = 8,
    localparam int REP_AW = $clog2(REPLY_DEPTH),
    localparam int COL_AW = $clog2(COLLECT_DEPTH),
    localparam int RIDX_W = $clog2(REPLY_DEPTH + 1),
    localparam int CIDX_W = $clog2(COLLECT_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        portb_i,
    input  logic [7:0]        aux_ctrl_i,
    input  logic              sr_we_i,
    input  logic [DW-1:0]     sr_wdata_i,
    input  logic              flag_clr_i,
    input  logic              rep_we_i,
    input  logic [REP_AW-1:0] rep_waddr_i,
    input  logic [DW-1:0]     rep_wdata_i,
    input  logic [RIDX_W-1:0] rep_len_i,
    input  logic              rep_commit_i,
    input  logic [COL_AW-1:0] col_raddr_i,
    output logic              treq_n_o,
    output logic [DW-1:0]     sr_o,
    output logic              sr_flag_o,
    output logic              pkt_valid_o,
    output logic [CIDX_W-1:0] pkt_len_o,
    output logic [DW-1:0]     col_rdata_o
);
    typedef struct packed {
        logic [DW-1:0]     sr;
        logic              flag;
        logic              treq_n;
        logic [RIDX_W-1:0] ridx;
        logic [RIDX_W-1:0] rcnt;
        logic [CIDX_W-1:0] widx;
        logic              pkt_valid;
        logic [CIDX_W-1:0] pkt_len;
    } eng_t;

    eng_t    st_d, st_q;
    hs_evt_t evt;

    logic              send_mode;
    logic [DW-1:0]     rep_rdata;
    logic              col_we;
    logic [COL_AW-1:0] col_waddr;
    logic [DW-1:0]     col_wdata;
    logic [RIDX_W-1:0] len_clamped;
    logic [RIDX_W-1:0] mon_ridx, mon_rcnt;
    logic [CIDX_W-1:0] mon_widx;
    logic              unused_ok;

    assign send_mode = aux_ctrl_i[DIR_BIT];
    assign unused_ok = ^{portb_i[7:6], portb_i[3:0], aux_ctrl_i[7:5], aux_ctrl_i[3:0]};

    link_hs_detect u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i ({portb_i[TIP_BIT], portb_i[ACK_BIT]}),
        .evt_o   (evt)
    );

    link_byte_store #(.DEPTH(REPLY_DEPTH), .DW(DW)) u_reply (
        .clk     (clk),
        .we_i    (rep_we_i),
        .waddr_i (rep_waddr_i),
        .wdata_i (rep_wdata_i),
        .raddr_i (st_q.ridx[REP_AW-1:0]),
        .rdata_o (rep_rdata)
    );

    link_byte_store #(.DEPTH(COLLECT_DEPTH), .DW(DW)) u_collect (
        .clk     (clk),
        .we_i    (col_we),
        .waddr_i (col_waddr),
        .wdata_i (col_wdata),
        .raddr_i (col_raddr_i),
        .rdata_o (col_rdata_o)
    );

    assign len_clamped = (rep_len_i > RIDX_W'(REPLY_DEPTH)) ? RIDX_W'(REPLY_DEPTH) : rep_len_i;

    always_comb begin
        st_d           = st_q;
        st_d.pkt_valid = 1'b0;
        col_we         = 1'b0;
        col_waddr      = st_q.widx[COL_AW-1:0];
        col_wdata      = st_q.sr;

        if (flag_clr_i) st_d.flag = 1'b0;
        if (sr_we_i)    st_d.sr   = sr_wdata_i;

        if (evt.tip_now) begin
            // transfer active: each change of the line pair moves a byte
            if (evt.pair_chg) begin
                if (send_mode) begin
                    if (st_q.widx < CIDX_W'(COLLECT_DEPTH)) begin
                        col_we    = 1'b1;
                        st_d.widx = st_q.widx + 1'b1;
                        st_d.flag = 1'b1;
                    end
                end else if (st_q.ridx < st_q.rcnt) begin
                    st_d.sr   = rep_rdata;
                    st_d.ridx = st_q.ridx + 1'b1;
                    st_d.flag = 1'b1;
                    if ((st_q.ridx + 1'b1) >= st_q.rcnt) st_d.treq_n = 1'b1;
                end
            end
        end else if (!evt.tip_prev && evt.ack_chg) begin
            // idle sync: request mirrors acknowledge
            st_d.treq_n = evt.ack_lvl;
            st_d.flag   = 1'b1;
        end else begin
            if (evt.tip_prev) begin
                st_d.flag = 1'b1;
                if (st_q.widx != '0) begin
                    st_d.pkt_valid = 1'b1;
                    st_d.pkt_len   = st_q.widx;
                    st_d.widx      = '0;
                end
            end
            if (st_q.ridx < st_q.rcnt) st_d.treq_n = 1'b0;
        end

        if (rep_commit_i) begin
            st_d.rcnt = len_clamped;
            st_d.ridx = '0;
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr        <= '0;
            st_q.flag      <= 1'b0;
            st_q.treq_n    <= 1'b1;
            st_q.ridx      <= '0;
            st_q.rcnt      <= '0;
            st_q.widx      <= '0;
            st_q.pkt_valid <= 1'b0;
            st_q.pkt_len   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign treq_n_o    = st_q.treq_n;
    assign sr_o        = st_q.sr;
    assign sr_flag_o   = st_q.flag;
    assign pkt_valid_o = st_q.pkt_valid;
    assign pkt_len_o   = st_q.pkt_len;
    assign mon_ridx    = st_q.ridx;
    assign mon_rcnt    = st_q.rcnt;
    assign mon_widx    = st_q.widx;
endmodule

// File: rtl/link_shift_engine_chk.sv
module link_shift_engine_chk #(
    parameter int REPLY_DEPTH   = 128,
    parameter int COLLECT_DEPTH = 16,
    localparam int RIDX_W = $clog2(REPLY_DEPTH + 1),
    localparam int CIDX_W = $clog2(COLLECT_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        hs_lines,
    input logic              send_bit,
    input logic              rep_commit_i,
    input logic              treq_n_o,
    input logic              sr_flag_o,
    input logic              pkt_valid_o,
    input logic [CIDX_W-1:0] pkt_len_o,
    input logic [RIDX_W-1:0] rd_idx,
    input logic [RIDX_W-1:0] rd_cnt,
    input logic [CIDX_W-1:0] wr_idx
);
    logic [1:0] seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 2'b11;
        else        seen_q <= hs_lines;
    end

    logic busy_now, busy_before, lines_moved, ack_moved, recv_step;
    assign busy_now    = ~hs_lines[1];
    assign busy_before = ~seen_q[1];
    assign lines_moved = hs_lines != seen_q;
    assign ack_moved   = hs_lines[0] != seen_q[0];
    assign recv_step   = busy_now && lines_moved && !send_bit && (rd_idx < rd_cnt) && !rep_commit_i;

    assert_rd_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_idx <= rd_cnt && rd_cnt <= RIDX_W'(REPLY_DEPTH));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_idx <= CIDX_W'(COLLECT_DEPTH));

    assert_pkt_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid_o |-> (pkt_len_o != '0) && sr_flag_o);

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_before && !busy_now && wr_idx != '0) |=> pkt_valid_o);

    assert_recv_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        recv_step |=> sr_flag_o && (rd_idx == $past(rd_idx) + 1'b1));

    assert_last_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (recv_step && (rd_idx + 1'b1 == rd_cnt)) |=> treq_n_o);

    assert_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_now && !busy_before && ack_moved) |=> treq_n_o == $past(hs_lines[0]));

    assert_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rep_commit_i |=> (rd_idx == '0) && sr_flag_o);
endmodule

bind link_shift_engine link_shift_engine_chk #(
    .REPLY_DEPTH   (REPLY_DEPTH),
    .COLLECT_DEPTH (COLLECT_DEPTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hs_lines     ({portb_i[5], portb_i[4]}),
    .send_bit     (aux_ctrl_i[4]),
    .rep_commit_i (rep_commit_i),
    .treq_n_o     (treq_n_o),
    .sr_flag_o    (sr_flag_o),
    .pkt_valid_o  (pkt_valid_o),
    .pkt_len_o    (pkt_len_o),
    .rd_idx       (mon_ridx),
    .rd_cnt       (mon_rcnt),
    .wr_idx       (mon_widx)
);

// File: tb/link_shift_engine_tb.sv
module link_shift_engine_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] portb_i = 8'h30;
    logic [7:0] aux_ctrl_i = 8'h10;
    logic       sr_we_i = 0;
    logic [7:0] sr_wdata_i = 0;
    logic       flag_clr_i = 0;
    logic       rep_we_i = 0;
    logic [6:0] rep_waddr_i = 0;
    logic [7:0] rep_wdata_i = 0;
    logic [7:0] rep_len_i = 0;
    logic       rep_commit_i = 0;
    logic [3:0] col_raddr_i = 0;
    logic       treq_n_o, sr_flag_o, pkt_valid_o;
    logic [7:0] sr_o, col_rdata_o;
    logic [4:0] pkt_len_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    always #5 clk = ~clk;

    link_shift_engine u_dut (
        .clk(clk), .rst_n(rst_n), .portb_i(portb_i), .aux_ctrl_i(aux_ctrl_i),
        .sr_we_i(sr_we_i), .sr_wdata_i(sr_wdata_i), .flag_clr_i(flag_clr_i),
        .rep_we_i(rep_we_i), .rep_waddr_i(rep_waddr_i), .rep_wdata_i(rep_wdata_i),
        .rep_len_i(rep_len_i), .rep_commit_i(rep_commit_i), .col_raddr_i(col_raddr_i),
        .treq_n_o(treq_n_o), .sr_o(sr_o), .sr_flag_o(sr_flag_o),
        .pkt_valid_o(pkt_valid_o), .pkt_len_o(pkt_len_o), .col_rdata_o(col_rdata_o)
    );

    // {portb, sr byte written first, exp flag, exp pkt pulse, exp treq_n}
    localparam logic [18:0] VEC [0:5] = '{
        {8'h10, 8'hA1, 1'b1, 1'b0, 1'b1},
        {8'h00, 8'hB2, 1'b1, 1'b0, 1'b1},
        {8'h10, 8'hC3, 1'b1, 1'b0, 1'b1},
        {8'h30, 8'h00, 1'b1, 1'b1, 1'b1},
        {8'h20, 8'h00, 1'b1, 1'b0, 1'b0},
        {8'h30, 8'h00, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_sr(input logic [7:0] d);
        sr_we_i = 1; sr_wdata_i = d; flag_clr_i = 1;
        @(negedge clk);
        sr_we_i = 0; flag_clr_i = 0;
    endtask

    task automatic clr();
        flag_clr_i = 1;
        @(negedge clk);
        flag_clr_i = 0;
    endtask

    task automatic drive(input logic [7:0] pb);
        portb_i = pb;
        @(negedge clk);
    endtask

    task automatic rep_load(input logic [6:0] a, input logic [7:0] d);
        rep_we_i = 1; rep_waddr_i = a; rep_wdata_i = d;
        @(negedge clk);
        rep_we_i = 0;
    endtask

    task automatic commit(input logic [7:0] len);
        rep_commit_i = 1; rep_len_i = len;
        @(negedge clk);
        rep_commit_i = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 treq_n", treq_n_o, 1);
        chk("R1 flag", sr_flag_o, 0);
        chk("R1 sr", sr_o, 8'h00);
        chk("R1 pkt", pkt_valid_o, 0);

        // table walk: send three bytes, release, then idle sync toggles
        aux_ctrl_i = 8'h10;
        for (int i = 0; i < 6; i++) begin
            wr_sr(VEC[i][10:3]);
            drive(VEC[i][18:11]);
            chk("R2/R5/R6 flag", sr_flag_o, VEC[i][2]);
            chk("R6 pkt_valid", pkt_valid_o, VEC[i][1]);
            chk("R5 treq_n", treq_n_o, VEC[i][0]);
            if (VEC[i][1]) chk("R6 pkt_len", pkt_len_o, 3);
        end
        col_raddr_i = 0; #1 chk("R2 byte0", col_rdata_o, 8'hA1);
        col_raddr_i = 1; #1 chk("R2 byte1", col_rdata_o, 8'hB2);
        col_raddr_i = 2; #1 chk("R2 byte2", col_rdata_o, 8'hC3);
        @(negedge clk);

        // R9 overflow: 18 bytes sent, 16 kept
        for (int i = 0; i < 18; i++) begin
            wr_sr(8'h40 + 8'(i));
            drive((i % 2 == 0) ? 8'h10 : 8'h00);
            if (i == 15) chk("R9 16th byte flag", sr_flag_o, 1);
            if (i == 16) chk("R9 dropped byte flag", sr_flag_o, 0);
        end
        drive(8'h30);
        chk("R9 pkt_valid", pkt_valid_o, 1);
        chk("R9 pkt_len", pkt_len_o, 16);
        col_raddr_i = 15; #1 chk("R9 last kept", col_rdata_o, 8'h4F);
        col_raddr_i = 0;  #1 chk("R9 first kept", col_rdata_o, 8'h40);
        @(negedge clk);

        // R11 host shift register write
        wr_sr(8'h99);
        chk("R11 sr write", sr_o, 8'h99);

        // receive path
        aux_ctrl_i = 8'h00;
        rep_load(0, 8'h5A); rep_load(1, 8'h6B); rep_load(2, 8'h7C);
        clr();
        commit(3);
        chk("R8 commit flag", sr_flag_o, 1);
        @(negedge clk);
        chk("R7 request pending", treq_n_o, 0);
        clr();
        drive(8'h10);
        chk("R3 first byte", sr_o, 8'h5A);
        chk("R3 flag", sr_flag_o, 1);
        chk("R4 not last", treq_n_o, 0);
        flag_clr_i = 1;
        drive(8'h00);
        flag_clr_i = 0;
        chk("R10 set wins", sr_flag_o, 1);
        chk("R3 second byte", sr_o, 8'h6B);
        clr();
        chk("R10 clear", sr_flag_o, 0);
        drive(8'h10);
        chk("R3 third byte", sr_o, 8'h7C);
        chk("R4 end of packet", treq_n_o, 1);
        clr();
        drive(8'h00);
        chk("R3 empty sr", sr_o, 8'h7C);
        chk("R3 empty flag", sr_flag_o, 0);
        drive(8'h20);
        chk("R6 release flag", sr_flag_o, 1);
        chk("R6 no pkt", pkt_valid_o, 0);
        chk("R7 nothing pending", treq_n_o, 1);

        // release with bytes left, then recommit restarts reading
        rep_load(0, 8'h11); rep_load(1, 8'h22);
        commit(2);
        @(negedge clk);
        drive(8'h00);
        chk("R3 partial", sr_o, 8'h11);
        drive(8'h20);
        @(negedge clk);
        chk("R7 pending after release", treq_n_o, 0);
        commit(2);
        drive(8'h00);
        chk("R8 index reset", sr_o, 8'h11);
        drive(8'h20);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule